// File: doc/BRIEF.md
# Write-Enable Latch with Command Framing Check

This block holds the write-enable state of a serial EEPROM slave. The command decoder upstream presents a decoded command byte together with the acknowledge type that the master sent after it. The block acts only on the two short commands that arm and disarm writing. Each of them takes effect only when the master closes it with a not-acknowledge, which ends the transfer. If the master acknowledges instead, the command is malformed. In that case the block asks the bus engine to drop back to idle, gives no slave acknowledge and leaves the latch alone.

Other instruction engines report a successful finish through one strobe each. Any such strobe disarms the latch, so every modifying operation needs a fresh enable. A write request from those engines is granted only while the latch is armed. A power-up reset disarms the latch. The two opcode values are parameters.

Top module: `wen_guard`

## Requirements
- R1: While `rstN` is low, `wrEnable`, `sakReq` and `idleReq` are 0, and they stay 0 until a command or strobe changes them.
- R2: With `cmdValid`=1, `cmdCode`=OPC_SET (default 8'h96) and `ackNomak`=1 (1 means the master sent a not-acknowledge), `wrEnable` is 1 after the next rising clock edge, provided no done strobe is active in the same cycle.
- R3: With `cmdValid`=1, `cmdCode`=OPC_CLR (default 8'h91) and `ackNomak`=1, `wrEnable` is 0 after the next rising clock edge.
- R4: A well-framed set or clear command raises `sakReq` for exactly one cycle, following the same edge. `idleReq` stays 0.
- R5: A set or clear command with `ackNomak`=0 (the master acknowledged) raises `idleReq` for exactly one cycle after the next edge. `sakReq` stays 0 and `wrEnable` keeps its value.
- R6: Any bit of `doneVec` set to 1 makes `wrEnable` 0 after the next rising edge. Bit 0 is the status-register write, bit 1 the array write, bit 2 the erase-all and bit 3 the set-all.
- R7: If a done strobe and a well-framed set command arrive in the same cycle, the clear wins and `wrEnable` is 0 afterwards. `sakReq` is still raised for the set command.
- R8: `writeGrant` is 1 in the same cycle as `writeReq` only while `wrEnable` is 1. Otherwise it is 0.
- R9: A command code other than the two opcodes, or any code with `cmdValid`=0, leaves `wrEnable` unchanged and raises neither `sakReq` nor `idleReq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low power-up reset |
| cmdValid | input | 1 | Command byte and its acknowledge type are present this cycle |
| cmdCode | input | OPC_W | Decoded command byte |
| ackNomak | input | 1 | 1 = not-acknowledge followed the command byte, 0 = acknowledge |
| doneVec | input | NUM_DONE | One success strobe per modifying instruction |
| writeReq | input | 1 | Internal request to start a write |
| wrEnable | output | 1 | Latch state |
| sakReq | output | 1 | One-cycle request to send a slave acknowledge |
| idleReq | output | 1 | One-cycle request to return to idle |
| writeGrant | output | 1 | Write request passed through the latch |

## Verification
The latch, `sakReq` and `idleReq` are registered. Each of them moves on the first rising edge after the stimulus cycle, and the two pulses fall again on the edge after that. `writeGrant` is combinational and follows `writeReq` within the same cycle. The bench drives inputs on the falling edge and samples registered results shortly after the next rising edge. It then idles the inputs and samples once more after the following edge, to confirm that each pulse lasts one cycle. The grant is sampled before any edge, with the request held.

// File: rtl/wen_pkg.sv
package wen_pkg;
  typedef struct packed {
    logic setEn;
    logic clrEn;
    logic sakGo;
    logic idleGo;
  } wenStrobes_t;
endpackage

// File: rtl/wen_guard_ctrl.sv
module wen_guard_ctrl
  import wen_pkg::*;
#(
  parameter int OPC_W = 8,
  parameter logic [OPC_W-1:0] OPC_SET = 8'h96,
  parameter logic [OPC_W-1:0] OPC_CLR = 8'h91,
  parameter int NUM_DONE = 4
) (
  input  logic                cmdValid,
  input  logic [OPC_W-1:0]    cmdCode,
  input  logic                ackNomak,
  input  logic [NUM_DONE-1:0] doneVec,
  output wenStrobes_t         strobes
);
  localparam int NUM_OPC = 2;
  localparam logic [NUM_OPC*OPC_W-1:0] OPC_TABLE = {OPC_CLR, OPC_SET};

  logic [NUM_OPC-1:0] hit;
  logic anyDone;

  for (genvar i = 0; i < NUM_OPC; i++) begin : g_match
    assign hit[i] = cmdValid && (cmdCode == OPC_TABLE[i*OPC_W +: OPC_W]);
  end

  assign anyDone = |doneVec;

  always_comb begin
    strobes.setEn  = hit[0] && ackNomak;
    strobes.clrEn  = (hit[1] && ackNomak) || anyDone;
    strobes.sakGo  = (|hit) && ackNomak;
    strobes.idleGo = (|hit) && !ackNomak;
  end
endmodule

// File: rtl/wen_guard_dp.sv
module wen_guard_dp
  import wen_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  wenStrobes_t strobes,
  input  logic        writeReq,
  output logic        wrEnable,
  output logic        sakReq,
  output logic        idleReq,
  output logic        writeGrant
);
  logic latchQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchQ  <= 1'b0;
      sakReq  <= 1'b0;
      idleReq <= 1'b0;
    end else begin
      if (strobes.clrEn)      latchQ <= 1'b0;
      else if (strobes.setEn) latchQ <= 1'b1;
      sakReq  <= strobes.sakGo;
      idleReq <= strobes.idleGo;
    end
  end

  assign wrEnable   = latchQ;
  assign writeGrant = writeReq && latchQ;
endmodule

// File: rtl/wen_guard.sv
module wen_guard
  import wen_pkg::*;
#(
  parameter int OPC_W = 8,
  parameter logic [OPC_W-1:0] OPC_SET = 8'h96,
  parameter logic [OPC_W-1:0] OPC_CLR = 8'h91,
  parameter int NUM_DONE = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cmdValid,
  input  logic [OPC_W-1:0]    cmdCode,
  input  logic                ackNomak,
  input  logic [NUM_DONE-1:0] doneVec,
  input  logic                writeReq,
  output logic                wrEnable,
  output logic                sakReq,
  output logic                idleReq,
  output logic                writeGrant
);
  wenStrobes_t strobes;

  wen_guard_ctrl #(
    .OPC_W(OPC_W), .OPC_SET(OPC_SET), .OPC_CLR(OPC_CLR), .NUM_DONE(NUM_DONE)
  ) u_ctrl (
    .cmdValid(cmdValid),
    .cmdCode (cmdCode),
    .ackNomak(ackNomak),
    .doneVec (doneVec),
    .strobes (strobes)
  );

  wen_guard_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .writeReq  (writeReq),
    .wrEnable  (wrEnable),
    .sakReq    (sakReq),
    .idleReq   (idleReq),
    .writeGrant(writeGrant)
  );
endmodule

// File: rtl/wen_guard_chk.sv
module wen_guard_chk #(
  parameter int OPC_W = 8,
  parameter logic [OPC_W-1:0] OPC_SET = 8'h96,
  parameter logic [OPC_W-1:0] OPC_CLR = 8'h91,
  parameter int NUM_DONE = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic                cmdValid,
  input logic [OPC_W-1:0]    cmdCode,
  input logic                ackNomak,
  input logic [NUM_DONE-1:0] doneVec,
  input logic                writeReq,
  input logic                wrEnable,
  input logic                sakReq,
  input logic                idleReq,
  input logic                writeGrant
);
  logic isSet, isClr;
  assign isSet = cmdValid && (cmdCode == OPC_SET);
  assign isClr = cmdValid && (cmdCode == OPC_CLR);

  // R2
  set_takes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isSet && ackNomak && !(|doneVec)) |=> wrEnable);

  // R3
  clr_takes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isClr && ackNomak) |=> !wrEnable);

  // R4
  sak_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    sakReq |-> $past((isSet || isClr) && ackNomak));

  // R5
  bad_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((isSet || isClr) && !ackNomak && !(|doneVec)) |=>
      (idleReq && !sakReq && $stable(wrEnable)));

  // R6
  done_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|doneVec) |=> !wrEnable);

  // R8
  grant_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    writeGrant |-> (wrEnable && writeReq));

  // R9
  rise_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wrEnable) |-> $past(isSet && ackNomak));

  // R5
  idle_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    idleReq |-> $past((isSet || isClr) && !ackNomak));
endmodule

bind wen_guard wen_guard_chk #(
  .OPC_W(OPC_W), .OPC_SET(OPC_SET), .OPC_CLR(OPC_CLR), .NUM_DONE(NUM_DONE)
) u_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
  .ackNomak(ackNomak), .doneVec(doneVec), .writeReq(writeReq),
  .wrEnable(wrEnable), .sakReq(sakReq), .idleReq(idleReq),
  .writeGrant(writeGrant)
);

// File: tb/sim_wen_guard.sv
`timescale 1ns/1ps
module sim_wen_guard;
  localparam logic [7:0] SETC = 8'h96;
  localparam logic [7:0] CLRC = 8'h91;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [7:0] cmdCode = 8'h00;
  logic ackNomak = 1'b0;
  logic [3:0] doneVec = 4'h0;
  logic writeReq = 1'b0;
  logic wrEnable, sakReq, idleReq, writeGrant;

  int testCnt = 0;
  int failCnt = 0;

  always #4 clk = ~clk;

  wen_guard u0 (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .ackNomak(ackNomak), .doneVec(doneVec), .writeReq(writeReq),
    .wrEnable(wrEnable), .sakReq(sakReq), .idleReq(idleReq),
    .writeGrant(writeGrant)
  );

  task automatic check(input string req, input logic act, input logic exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  // Drive one command cycle at the falling edge, then sample after the rise.
  task automatic pulse(input logic v, input logic [7:0] c, input logic n,
                       input logic [3:0] d);
    @(negedge clk);
    cmdValid = v; cmdCode = c; ackNomak = n; doneVec = d;
    @(posedge clk); #1;
  endtask

  // Idle the inputs for one cycle and sample after the rise.
  task automatic quiet();
    @(negedge clk);
    cmdValid = 1'b0; cmdCode = 8'h00; ackNomak = 1'b0; doneVec = 4'h0;
    @(posedge clk); #1;
  endtask

  task automatic tReset();
    check("R1 latch in reset", wrEnable, 1'b0);
    check("R1 sak in reset", sakReq, 1'b0);
    check("R1 idle in reset", idleReq, 1'b0);
    @(negedge clk); rstN = 1'b1;
    quiet();
    check("R1 latch after release", wrEnable, 1'b0);
  endtask

  task automatic tSetValid();
    pulse(1'b1, SETC, 1'b1, 4'h0);
    check("R2 set latch", wrEnable, 1'b1);
    check("R4 set sak", sakReq, 1'b1);
    check("R4 set no idle", idleReq, 1'b0);
    quiet();
    check("R4 sak one cycle", sakReq, 1'b0);
    check("R2 latch holds", wrEnable, 1'b1);
  endtask

  task automatic tClrValid();
    pulse(1'b1, CLRC, 1'b1, 4'h0);
    check("R3 clear latch", wrEnable, 1'b0);
    check("R4 clear sak", sakReq, 1'b1);
    quiet();
    check("R4 clear sak one cycle", sakReq, 1'b0);
  endtask

  task automatic tSetInvalid();
    pulse(1'b1, SETC, 1'b0, 4'h0);
    check("R5 bad set keeps latch", wrEnable, 1'b0);
    check("R5 bad set idle", idleReq, 1'b1);
    check("R5 bad set no sak", sakReq, 1'b0);
    quiet();
    check("R5 idle one cycle", idleReq, 1'b0);
  endtask

  task automatic tClrInvalid();
    pulse(1'b1, SETC, 1'b1, 4'h0);
    quiet();
    pulse(1'b1, CLRC, 1'b0, 4'h0);
    check("R5 bad clear keeps latch", wrEnable, 1'b1);
    check("R5 bad clear idle", idleReq, 1'b1);
    check("R5 bad clear no sak", sakReq, 1'b0);
    quiet();
    check("R5 latch still set", wrEnable, 1'b1);
  endtask

  task automatic tDoneEach();
    for (int i = 0; i < 4; i++) begin
      pulse(1'b1, SETC, 1'b1, 4'h0);
      quiet();
      check("R6 armed before strobe", wrEnable, 1'b1);
      pulse(1'b0, 8'h00, 1'b0, 4'h1 << i);
      check($sformatf("R6 done bit %0d clears", i), wrEnable, 1'b0);
      check("R6 no sak on done", sakReq, 1'b0);
    end
    quiet();
  endtask

  task automatic tCollision();
    pulse(1'b1, SETC, 1'b1, 4'b0010);
    check("R7 clear wins", wrEnable, 1'b0);
    check("R7 sak still given", sakReq, 1'b1);
    quiet();
  endtask

  task automatic tGrant();
    @(negedge clk); writeReq = 1'b1; #1;
    check("R8 grant blocked", writeGrant, 1'b0);
    writeReq = 1'b0;
    pulse(1'b1, SETC, 1'b1, 4'h0);
    quiet();
    @(negedge clk); writeReq = 1'b1; #1;
    check("R8 grant passed", writeGrant, 1'b1);
    writeReq = 1'b0; #1;
    check("R8 no request no grant", writeGrant, 1'b0);
  endtask

  task automatic tOther();
    pulse(1'b1, 8'h55, 1'b1, 4'h0);
    check("R9 other code keeps latch", wrEnable, 1'b1);
    check("R9 other code no sak", sakReq, 1'b0);
    check("R9 other code no idle", idleReq, 1'b0);
    pulse(1'b0, CLRC, 1'b1, 4'h0);
    check("R9 invalid strobe keeps latch", wrEnable, 1'b1);
    check("R9 invalid strobe no sak", sakReq, 1'b0);
    pulse(1'b0, SETC, 1'b0, 4'h0);
    check("R9 invalid strobe no idle", idleReq, 1'b0);
    quiet();
  endtask

  initial begin
    #20;
    tReset();
    tSetValid();
    tClrValid();
    tSetInvalid();
    tClrInvalid();
    tDoneEach();
    tCollision();
    tGrant();
    tOther();
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    #(8 * 200000);
    testCnt++;
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule